// File: doc/BRIEF.md
# Masked Content-Addressable Memory

This block is a small associative store. Each of its slots keeps a tag, a data word and an occupied flag. A lookup presents a key, and every occupied slot compares its tag against that key in the same cycle. A programmable bit mask decides which key positions take part in the comparison. Positions that are masked off always agree.

The per-slot results are captured in a hit vector. Three outcome flags are decoded from that vector: nothing matched, exactly one slot matched, or several slots matched. A lookup with exactly one hit copies that slot's data word into an output register. A store finds a vacant slot by running the same comparison path with only the occupied flag enabled, looking for zero. A flush command empties every slot.

Top module: `masked_cam`

## Requirements
- R1: A lookup (`cmd_op` = 2'b00) compares `cmd_key` in one cycle against the tag of every occupied slot. A slot hits when all key bits whose mask bit is 1 equal the stored tag bits. Vacant slots never hit.
- R2: A mask load (`cmd_op` = 2'b11) copies `cmd_key` into the mask register. A mask bit of 1 makes that position take part in the comparison, and a mask bit of 0 makes it always agree. Reset sets the mask to all ones. A mask load leaves the hit vector, the data output and every slot unchanged.
- R3: Lookup and store results are latched into a hit vector with one bit per slot. Exactly one of `no_hit`, `one_hit` and `multi_hit` is high, decoded from that vector: zero bits set, one bit set, or more than one bit set. The vector keeps its value while no command is given.
- R4: A lookup with exactly one hit loads that slot's data word into `rd_data`, with `hit_idx` giving the slot number.
- R5: A lookup with several hits reports the lowest-numbered hit in `hit_idx` and leaves `rd_data` unchanged. With no hits, `hit_idx` is 0 and `rd_data` is unchanged.
- R6: A store (`cmd_op` = 2'b01) writes `cmd_key` and `cmd_data` into the lowest-numbered vacant slot and marks that slot occupied. The hit vector then holds the vacancy vector seen before the store, so `hit_idx` names the slot that was used.
- R7: A store when no slot is vacant raises `full_err`, changes no slot, and leaves the hit vector all zero. `full_err` is cleared by the next command.
- R8: A flush (`cmd_op` = 2'b10) marks every slot vacant and clears the hit vector. `rd_data` is unchanged.
- R9: `done` is high for exactly the one cycle after each accepted command. After reset, `done` is 0, `no_hit` is 1, `rd_data` is 0 and `full_err` is 0.

Ports, in the order of the port list:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_op | input | 2 | 00 lookup, 01 store, 10 flush, 11 mask load |
| cmd_key | input | 16 | Lookup key, store tag or mask value |
| cmd_data | input | 16 | Data word for a store |
| done | output | 1 | Completion pulse, one cycle after the command |
| no_hit | output | 1 | Hit vector is all zero |
| one_hit | output | 1 | Hit vector has exactly one bit set |
| multi_hit | output | 1 | Hit vector has two or more bits set |
| hit_idx | output | 3 | Lowest set position of the hit vector |
| rd_data | output | 16 | Data word of the last single-hit lookup |
| full_err | output | 1 | Last store found no vacant slot |

## Verification
A corrupted occupied flag or a wrong stored tag shows up at the ports on the next lookup or store. A lookup that should hit reports no hit, or a store lands in the wrong slot, and `hit_idx` and the outcome flags reveal the error one cycle after the command. A stale mask register turns an expected multi-hit into a single hit that loads `rd_data` when it should not. This difference is visible in the `done` cycle. Each occupied flag is checked indirectly, by filling every slot until a store fails, then flushing and storing again.

// File: rtl/masked_cam.sv
module masked_cam #(
  parameter int ENTRIES = 8,
  parameter int TAG_W   = 16,
  parameter int DATA_W  = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cmd_valid,
  input  logic [1:0]                 cmd_op,
  input  logic [TAG_W-1:0]           cmd_key,
  input  logic [DATA_W-1:0]          cmd_data,
  output logic                       done,
  output logic                       no_hit,
  output logic                       one_hit,
  output logic                       multi_hit,
  output logic [$clog2(ENTRIES)-1:0] hit_idx,
  output logic [DATA_W-1:0]          rd_data,
  output logic                       full_err
);
  localparam int IW = $clog2(ENTRIES);
  localparam int CW = TAG_W + 1;

  logic [TAG_W-1:0]   tag_q  [ENTRIES];
  logic [DATA_W-1:0]  data_q [ENTRIES];
  logic [ENTRIES-1:0] busy_q;
  logic [ENTRIES-1:0] match_q;
  logic [TAG_W-1:0]   mask_q;

  wire op_find  = cmd_valid && cmd_op == 2'b00;
  wire op_store = cmd_valid && cmd_op == 2'b01;
  wire op_flush = cmd_valid && cmd_op == 2'b10;
  wire op_mask  = cmd_valid && cmd_op == 2'b11;

  wire [CW-1:0] want = {~op_store, cmd_key};
  wire [CW-1:0] care = op_store ? {1'b1, {TAG_W{1'b0}}} : {1'b1, mask_q};

  logic [ENTRIES-1:0] cmp;
  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign cmp[i] = ((({busy_q[i], tag_q[i]}) ^ want) & care) == '0;
  end

  function automatic logic [IW-1:0] lowest(input logic [ENTRIES-1:0] v);
    lowest = '0;
    for (int k = ENTRIES - 1; k >= 0; k--)
      if (v[k]) lowest = IW'(k);
  endfunction

  wire [IW-1:0] cmp_idx  = lowest(cmp);
  wire          cmp_any  = |cmp;
  wire          cmp_many = |(cmp & (cmp - 1'b1));

  assign no_hit    = ~|match_q;
  assign multi_hit = |(match_q & (match_q - 1'b1));
  assign one_hit   = ~no_hit & ~multi_hit;
  assign hit_idx   = lowest(match_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= '0;
      match_q  <= '0;
      mask_q   <= '1;
      rd_data  <= '0;
      done     <= 1'b0;
      full_err <= 1'b0;
      for (int k = 0; k < ENTRIES; k++) begin
        tag_q[k]  <= '0;
        data_q[k] <= '0;
      end
    end else begin
      done <= cmd_valid;
      if (cmd_valid) full_err <= 1'b0;
      if (op_find) begin
        match_q <= cmp;
        if (cmp_any && !cmp_many) rd_data <= data_q[cmp_idx];
      end
      if (op_store) begin
        match_q <= cmp;
        if (cmp_any) begin
          tag_q[cmp_idx]  <= cmd_key;
          data_q[cmp_idx] <= cmd_data;
          busy_q[cmp_idx] <= 1'b1;
        end else begin
          full_err <= 1'b1;
        end
      end
      if (op_flush) begin
        busy_q  <= '0;
        match_q <= '0;
      end
      if (op_mask) mask_q <= cmd_key;
    end
  end

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> done);
  p_done_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> !done);
  p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> $stable(match_q) && $stable(rd_data));
  p_multi_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_find && cmp_many) |=> $stable(rd_data) && multi_hit);
  p_full_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_store && &busy_q) |=> $stable(busy_q) && full_err && no_hit);
  p_flush_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    op_flush |=> busy_q == '0 && no_hit);
  p_mask_inert_r2: assert property (@(posedge clk) disable iff (!rst_n)
    op_mask |=> $stable(busy_q) && $stable(match_q) && $stable(rd_data));
  p_store_grow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_store && !(&busy_q)) |=> $countones(busy_q) == $countones($past(busy_q)) + 1);
endmodule

// File: tb/sim_masked_cam.sv
`timescale 1ns/1ps
module sim_masked_cam;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = 2'b00;
  logic [15:0] cmd_key = '0;
  logic [15:0] cmd_data = '0;
  logic        done, no_hit, one_hit, multi_hit, full_err;
  logic [2:0]  hit_idx;
  logic [15:0] rd_data;

  int errs = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  masked_cam u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_key(cmd_key), .cmd_data(cmd_data), .done(done), .no_hit(no_hit),
    .one_hit(one_hit), .multi_hit(multi_hit), .hit_idx(hit_idx),
    .rd_data(rd_data), .full_err(full_err)
  );

  typedef struct packed {
    logic [1:0]  op;
    logic [15:0] key;
    logic [15:0] wd;
    logic [2:0]  hits;
    logic [2:0]  idx;
    logic [15:0] rd;
    logic        full;
  } vec_t;

  localparam logic [2:0] NONE = 3'b100, ONE = 3'b010, MANY = 3'b001;
  localparam logic [1:0] FIND = 2'b00, STORE = 2'b01, FLUSH = 2'b10, MASK = 2'b11;

  localparam vec_t TBL [28] = '{
    '{FIND,  16'h1234, 16'h0000, NONE, 3'd0, 16'h0000, 1'b0},
    '{STORE, 16'h1234, 16'hAAAA, MANY, 3'd0, 16'h0000, 1'b0},
    '{STORE, 16'h1250, 16'hBBBB, MANY, 3'd1, 16'h0000, 1'b0},
    '{STORE, 16'h3434, 16'hCCCC, MANY, 3'd2, 16'h0000, 1'b0},
    '{FIND,  16'h1234, 16'h0000, ONE,  3'd0, 16'hAAAA, 1'b0},
    '{FIND,  16'h1250, 16'h0000, ONE,  3'd1, 16'hBBBB, 1'b0},
    '{FIND,  16'h9999, 16'h0000, NONE, 3'd0, 16'hBBBB, 1'b0},
    '{MASK,  16'hFF00, 16'h0000, NONE, 3'd0, 16'hBBBB, 1'b0},
    '{FIND,  16'h12FF, 16'h0000, MANY, 3'd0, 16'hBBBB, 1'b0},
    '{FIND,  16'h34FF, 16'h0000, ONE,  3'd2, 16'hCCCC, 1'b0},
    '{MASK,  16'h00FF, 16'h0000, ONE,  3'd2, 16'hCCCC, 1'b0},
    '{FIND,  16'hFF34, 16'h0000, MANY, 3'd0, 16'hCCCC, 1'b0},
    '{FIND,  16'h0050, 16'h0000, ONE,  3'd1, 16'hBBBB, 1'b0},
    '{MASK,  16'h0000, 16'h0000, ONE,  3'd1, 16'hBBBB, 1'b0},
    '{FIND,  16'h0000, 16'h0000, MANY, 3'd0, 16'hBBBB, 1'b0},
    '{MASK,  16'hFFFF, 16'h0000, MANY, 3'd0, 16'hBBBB, 1'b0},
    '{STORE, 16'h4000, 16'hD000, MANY, 3'd3, 16'hBBBB, 1'b0},
    '{STORE, 16'h4001, 16'hD001, MANY, 3'd4, 16'hBBBB, 1'b0},
    '{STORE, 16'h4002, 16'hD002, MANY, 3'd5, 16'hBBBB, 1'b0},
    '{STORE, 16'h4003, 16'hD003, MANY, 3'd6, 16'hBBBB, 1'b0},
    '{STORE, 16'h4004, 16'hD004, ONE,  3'd7, 16'hBBBB, 1'b0},
    '{STORE, 16'h5555, 16'hFFFF, NONE, 3'd0, 16'hBBBB, 1'b1},
    '{FIND,  16'h5555, 16'h0000, NONE, 3'd0, 16'hBBBB, 1'b0},
    '{FIND,  16'h4004, 16'h0000, ONE,  3'd7, 16'hD004, 1'b0},
    '{FLUSH, 16'h0000, 16'h0000, NONE, 3'd0, 16'hD004, 1'b0},
    '{FIND,  16'h1234, 16'h0000, NONE, 3'd0, 16'hD004, 1'b0},
    '{STORE, 16'h7777, 16'hEEEE, MANY, 3'd0, 16'hD004, 1'b0},
    '{FIND,  16'h7777, 16'h0000, ONE,  3'd0, 16'hEEEE, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] op, input logic [15:0] key, input logic [15:0] wd);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_key = key; cmd_data = wd;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset done", 32'(done), 32'd0);
    check("R9 reset no_hit", 32'(no_hit), 32'd1);
    check("R9 reset rd_data", 32'(rd_data), 32'd0);
    check("R9 reset full_err", 32'(full_err), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 28; i++) begin
      issue(TBL[i].op, TBL[i].key, TBL[i].wd);
      // R1 R2 R3 R4 R5 R6 R7 R8: outcome, index, data and error after each command
      check("R9 done pulse", 32'(done), 32'd1);
      check("R1/R3 outcome flags", 32'({no_hit, one_hit, multi_hit}), 32'(TBL[i].hits));
      check("R5/R6 hit_idx", 32'(hit_idx), 32'(TBL[i].idx));
      check("R4/R5 rd_data", 32'(rd_data), 32'(TBL[i].rd));
      check("R7 full_err", 32'(full_err), 32'(TBL[i].full));
    end

    // R9: done drops after one cycle; R3: hit vector held while idle
    @(negedge clk);
    check("R9 done single cycle", 32'(done), 32'd0);
    check("R3 idle hold", 32'({no_hit, one_hit, multi_hit, hit_idx}), 32'({ONE, 3'd0}));

    // R2: reset restores the full mask, so a partial key no longer matches
    issue(MASK, 16'h00FF, 16'h0000);
    rst_n = 1'b0;
    @(negedge clk);
    check("R9 mid reset no_hit", 32'(no_hit), 32'd1);
    check("R9 mid reset rd_data", 32'(rd_data), 32'd0);
    rst_n = 1'b1;
    issue(STORE, 16'hAB12, 16'h5A5A);
    issue(FIND, 16'h0012, 16'h0000);
    check("R2 reset mask all ones", 32'(no_hit), 32'd1);
    issue(FIND, 16'hAB12, 16'h0000);
    check("R4 lookup after reset", 32'(rd_data), 32'h5A5A);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule